// File: doc/BRIEF.md
# Event Timer Register Interface

This block is the bus-facing register file of a multi-channel event timer. It owns the 64-bit main counter, a capability word, the global configuration and the per-channel interrupt status. It also holds the register window of every implemented channel: configuration, comparator and route. A simple word bus reads and writes all of these. The comparison logic and interrupt routing of each channel sit outside the block. They take the stored channel values from the flat output buses and react to the one-cycle write strobes.

The main counter is governed by a two-state machine. In `CNT_HALT` the counter holds its value. In `CNT_RUN` it advances by one on every clock. A write of the global configuration word with bit 0 set takes the transition `go` from `CNT_HALT` to `CNT_RUN`. A write with bit 0 clear takes the transition `stop` from `CNT_RUN` back to `CNT_HALT`. Each state stays where it is on any other cycle. Stopping keeps the count, and starting again continues from the held value. Either counter half can be written at any time.

Channels report events on a status input. Software clears status bits by writing ones to the status register, and the block then pulses a clear output so the channel can drop its level interrupt.

Top module: `evt_regif`

## Requirements
- R1: After reset the counter, global configuration (glb_enable, glb_legacy) and status are zero, rvalid and all strobes are low, every channel configuration low word reads 0x00000030, and every comparator reads all ones.
- R2: Offset 0x000 reads 0x8086A001 with (NUM_CH-1) placed in bits 12:8, and offset 0x004 reads TICK_FS. Writes to both offsets are ignored.
- R3: Offset 0x010 holds enable in bit 0 and legacy replacement in bit 1, and all its other bits read zero. Offset 0x014 always reads zero.
- R4: The counter advances by one at every clock edge where the machine was in CNT_RUN before that edge, and it holds in CNT_HALT. Stopping freezes the value, and starting again resumes from it.
- R5: The counter low word at 0x0F0 and high word at 0x0F4 are writable in either state. A write takes priority over the increment at that edge.
- R6: Status at 0x020 has one bit per channel, and a sts_set pulse sets the bit. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A set in the same cycle as a clear wins. In the cycle after a clear, sts_clr pulses for each bit that was set and has actually been cleared.
- R7: Channel n occupies 0x100+0x20*n. Its configuration sits at +0x00 (low) and +0x04 (high, read-only, returns ROUTE_CAP). Its comparator sits at +0x08/+0x0C and its route at +0x10/+0x14.
- R8: A channel configuration low write changes only the bits in mask 0x00007FCE. Bits 4 and 5 read as one, and all other bits keep their value.
- R9: A channel index at or above NUM_CH reads zero, and writes to it change nothing and raise no strobe.
- R10: One cycle after a write, ch_cfg_wr[n] pulses for a channel configuration low write and ch_cmp_wr[n] pulses for either comparator half. Each pulse coincides with the updated value on the output bus.
- R11: Read data appears with bus_rvalid one cycle after bus_rd. Unmapped offsets and addresses with bits 1:0 nonzero read zero, and writes to such misaligned addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | Byte address of the word access |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| sts_set | input | NUM_CH | Per-channel status set pulses |
| sts_clr | output | NUM_CH | Per-channel status cleared pulse |
| cnt_value | output | 64 | Main counter |
| glb_enable | output | 1 | Counter running (machine in CNT_RUN) |
| glb_legacy | output | 1 | Legacy replacement bit |
| ch_cfg | output | NUM_CH*32 | Channel configuration low words, channel 0 in the LSBs |
| ch_cmp | output | NUM_CH*64 | Channel comparators |
| ch_route | output | NUM_CH*64 | Channel route words |
| ch_cfg_wr | output | NUM_CH | Configuration write strobes |
| ch_cmp_wr | output | NUM_CH | Comparator write strobes |

## Verification
The bench builds the block with NUM_CH = 3, TICK_FS = 10,000,000 and ROUTE_CAP = 0x00F00000. Three channels leave windows 3 to 23 unimplemented inside the channel range, so the bench can reach both the in-range and the out-of-range decode. The channel-count field then reads a nonzero value of 2, which shows it is inserted and not left at the base pattern. The tick period and route capability are distinctive patterns, so a swapped or truncated word shows up on readback.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int ADDR_W = 10;

    typedef enum logic {
        CNT_HALT = 1'b0,
        CNT_RUN  = 1'b1
    } cnt_state_e;

    // global word offsets
    localparam logic [ADDR_W-1:0] OFF_CAP_LO  = 10'h000;
    localparam logic [ADDR_W-1:0] OFF_CAP_HI  = 10'h004;
    localparam logic [ADDR_W-1:0] OFF_GCFG    = 10'h010;
    localparam logic [ADDR_W-1:0] OFF_STS     = 10'h020;
    localparam logic [ADDR_W-1:0] OFF_CNT_LO  = 10'h0F0;
    localparam logic [ADDR_W-1:0] OFF_CNT_HI  = 10'h0F4;
    localparam logic [ADDR_W-1:0] CH_BASE     = 10'h100;

    // channel window: 32-byte stride
    localparam int               CH_STRIDE_LOG2 = 5;
    localparam int               IDX_W          = ADDR_W - CH_STRIDE_LOG2;
    localparam logic [IDX_W-1:0] CH_BASE_IDX    = IDX_W'(CH_BASE >> CH_STRIDE_LOG2);

    localparam logic [4:0] CHO_CFG_LO = 5'h00;
    localparam logic [4:0] CHO_CFG_HI = 5'h04;
    localparam logic [4:0] CHO_CMP_LO = 5'h08;
    localparam logic [4:0] CHO_CMP_HI = 5'h0C;
    localparam logic [4:0] CHO_RT_LO  = 5'h10;
    localparam logic [4:0] CHO_RT_HI  = 5'h14;

    localparam logic [31:0] CAP_BASE    = 32'h8086_A001;
    localparam int          CAP_NCH_LSB = 8;

    localparam int GCFG_EN_BIT  = 0;
    localparam int GCFG_LEG_BIT = 1;

    localparam logic [31:0] CHCFG_WMASK = 32'h0000_7FCE;
    localparam logic [31:0] CHCFG_RESET = 32'h0000_0030;

endpackage

// File: rtl/evt_cnt_fsm.sv
module evt_cnt_fsm
    import evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_wr,
    input  logic        en_val,
    input  logic        lo_wr,
    input  logic        hi_wr,
    input  logic [31:0] wdata,
    output logic [63:0] count,
    output logic        running
);

    cnt_state_e state_q, state_d;
    logic [63:0] count_q, count_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CNT_HALT;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    // transitions and counter next value
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        unique case (state_q)
            CNT_HALT: begin
                if (en_wr && en_val) state_d = CNT_RUN;   // go
            end
            CNT_RUN: begin
                count_d = count_q + 64'd1;
                if (en_wr && !en_val) state_d = CNT_HALT; // stop
            end
        endcase
        if (lo_wr) count_d[31:0]  = wdata;
        if (hi_wr) count_d[63:32] = wdata;
    end

    assign count   = count_q;
    assign running = (state_q == CNT_RUN);

endmodule

// File: rtl/evt_ch_bank.sv
module evt_ch_bank
    import evt_pkg::*;
#(
    parameter logic [31:0] ROUTE_CAP = 32'h00F0_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_sel,
    input  logic [4:0]  off,
    input  logic [31:0] wdata,
    output logic [31:0] cfg,
    output logic [63:0] cmp,
    output logic [63:0] route,
    output logic        cfg_wr,
    output logic        cmp_wr,
    output logic [31:0] rdata
);

    logic [31:0] cfg_q;
    logic [63:0] cmp_q, route_q;
    logic        cfg_wr_q, cmp_wr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= CHCFG_RESET;
            cmp_q    <= '1;
            route_q  <= '0;
            cfg_wr_q <= 1'b0;
            cmp_wr_q <= 1'b0;
        end else begin
            cfg_wr_q <= 1'b0;
            cmp_wr_q <= 1'b0;
            if (wr_sel) begin
                case (off)
                    CHO_CFG_LO: begin
                        cfg_q    <= (cfg_q & ~CHCFG_WMASK) | (wdata & CHCFG_WMASK);
                        cfg_wr_q <= 1'b1;
                    end
                    CHO_CMP_LO: begin
                        cmp_q[31:0] <= wdata;
                        cmp_wr_q    <= 1'b1;
                    end
                    CHO_CMP_HI: begin
                        cmp_q[63:32] <= wdata;
                        cmp_wr_q     <= 1'b1;
                    end
                    CHO_RT_LO: route_q[31:0]  <= wdata;
                    CHO_RT_HI: route_q[63:32] <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (off)
            CHO_CFG_LO: rdata = cfg_q;
            CHO_CFG_HI: rdata = ROUTE_CAP;
            CHO_CMP_LO: rdata = cmp_q[31:0];
            CHO_CMP_HI: rdata = cmp_q[63:32];
            CHO_RT_LO:  rdata = route_q[31:0];
            CHO_RT_HI:  rdata = route_q[63:32];
            default:    rdata = '0;
        endcase
    end

    assign cfg    = cfg_q;
    assign cmp    = cmp_q;
    assign route  = route_q;
    assign cfg_wr = cfg_wr_q;
    assign cmp_wr = cmp_wr_q;

endmodule

// File: rtl/evt_regif.sv
module evt_regif
    import evt_pkg::*;
#(
    parameter int          NUM_CH    = 3,
    parameter logic [31:0] TICK_FS   = 32'd10_000_000,
    parameter logic [31:0] ROUTE_CAP = 32'h00F0_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 bus_rvalid,
    input  logic [NUM_CH-1:0]    sts_set,
    output logic [NUM_CH-1:0]    sts_clr,
    output logic [63:0]          cnt_value,
    output logic                 glb_enable,
    output logic                 glb_legacy,
    output logic [NUM_CH*32-1:0] ch_cfg,
    output logic [NUM_CH*64-1:0] ch_cmp,
    output logic [NUM_CH*64-1:0] ch_route,
    output logic [NUM_CH-1:0]    ch_cfg_wr,
    output logic [NUM_CH-1:0]    ch_cmp_wr
);

    localparam logic [IDX_W-1:0] NCH_IDX = IDX_W'(NUM_CH);
    localparam logic [31:0]      CAP_LO  = CAP_BASE | (32'(NUM_CH - 1) << CAP_NCH_LSB);

    // decode
    logic             aligned, wr_ok, is_chan, in_range;
    logic [IDX_W-1:0] ch_idx;
    logic [4:0]       ch_off;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign wr_ok    = bus_wr && aligned;
    assign is_chan  = (bus_addr >= CH_BASE);
    assign ch_idx   = bus_addr[ADDR_W-1:CH_STRIDE_LOG2] - CH_BASE_IDX;
    assign ch_off   = bus_addr[CH_STRIDE_LOG2-1:0];
    assign in_range = is_chan && (ch_idx < NCH_IDX);

    // counter and run/halt machine
    logic [63:0] count;
    logic        running;

    evt_cnt_fsm u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_wr   (wr_ok && bus_addr == OFF_GCFG),
        .en_val  (bus_wdata[GCFG_EN_BIT]),
        .lo_wr   (wr_ok && bus_addr == OFF_CNT_LO),
        .hi_wr   (wr_ok && bus_addr == OFF_CNT_HI),
        .wdata   (bus_wdata),
        .count   (count),
        .running (running)
    );

    // legacy bit and status
    logic              legacy_q;
    logic [NUM_CH-1:0] sts_q, clr_vec, sts_clr_q;

    assign clr_vec = (wr_ok && bus_addr == OFF_STS) ? bus_wdata[NUM_CH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            legacy_q  <= 1'b0;
            sts_q     <= '0;
            sts_clr_q <= '0;
        end else begin
            if (wr_ok && bus_addr == OFF_GCFG) legacy_q <= bus_wdata[GCFG_LEG_BIT];
            sts_q     <= (sts_q & ~clr_vec) | sts_set;
            sts_clr_q <= clr_vec & sts_q & ~sts_set;
        end
    end

    // channel banks
    logic [31:0] ch_rd [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic sel;
        assign sel = wr_ok && in_range && (ch_idx == IDX_W'(g));
        evt_ch_bank #(.ROUTE_CAP(ROUTE_CAP)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_sel (sel),
            .off    (ch_off),
            .wdata  (bus_wdata),
            .cfg    (ch_cfg[g*32 +: 32]),
            .cmp    (ch_cmp[g*64 +: 64]),
            .route  (ch_route[g*64 +: 64]),
            .cfg_wr (ch_cfg_wr[g]),
            .cmp_wr (ch_cmp_wr[g]),
            .rdata  (ch_rd[g])
        );
    end

    // read path
    logic [31:0] rd_mux;
    logic [31:0] rdata_q;
    logic        rvalid_q;

    always_comb begin
        rd_mux = '0;
        if (is_chan) begin
            if (in_range) begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (ch_idx == IDX_W'(i)) rd_mux = ch_rd[i];
                end
            end
        end else begin
            case (bus_addr)
                OFF_CAP_LO: rd_mux = CAP_LO;
                OFF_CAP_HI: rd_mux = TICK_FS;
                OFF_GCFG:   rd_mux = {30'b0, legacy_q, running};
                OFF_STS:    rd_mux = 32'(sts_q);
                OFF_CNT_LO: rd_mux = count[31:0];
                OFF_CNT_HI: rd_mux = count[63:32];
                default:    rd_mux = '0;
            endcase
        end
        if (!aligned) rd_mux = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= bus_rd;
            if (bus_rd) rdata_q <= rd_mux;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;
    assign sts_clr    = sts_clr_q;
    assign cnt_value  = count;
    assign glb_enable = running;
    assign glb_legacy = legacy_q;

endmodule

// File: rtl/evt_regif_chk.sv
module evt_regif_chk
    import evt_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              bus_rvalid,
    input logic [63:0]       cnt_value,
    input logic              glb_enable,
    input logic [NUM_CH-1:0] sts_q,
    input logic [NUM_CH-1:0] sts_clr,
    input logic [NUM_CH-1:0] ch_cfg_wr,
    input logic [NUM_CH-1:0] ch_cmp_wr
);

    logic cnt_wr_now, oor_now;
    logic [IDX_W-1:0] idx;

    assign cnt_wr_now = bus_wr && (bus_addr[ADDR_W-1:3] == 7'h1E) && (bus_addr[1:0] == 2'b00);
    assign idx        = bus_addr[ADDR_W-1:CH_STRIDE_LOG2] - CH_BASE_IDX;
    assign oor_now    = (bus_addr >= CH_BASE) && (idx >= IDX_W'(NUM_CH));

    a_r4_hold_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_enable && !cnt_wr_now) |=> $stable(cnt_value));

    a_r4_step_when_running: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_enable && !cnt_wr_now) |=> (cnt_value == $past(cnt_value) + 64'd1));

    a_r11_rvalid_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    a_r11_rvalid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    a_r10_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_cfg_wr) && $onehot0(ch_cmp_wr));

    a_r9_no_strobe_oor: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && oor_now) |=> (ch_cfg_wr == '0 && ch_cmp_wr == '0));

    a_r6_clr_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        (|sts_clr) |-> $past(bus_wr && bus_addr == OFF_STS));

    a_r6_cleared_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_clr & sts_q) == '0));

endmodule

bind evt_regif evt_regif_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rvalid (bus_rvalid),
    .cnt_value  (cnt_value),
    .glb_enable (glb_enable),
    .sts_q      (sts_q),
    .sts_clr    (sts_clr),
    .ch_cfg_wr  (ch_cfg_wr),
    .ch_cmp_wr  (ch_cmp_wr)
);

// File: tb/evt_regif_tb_top.sv
module evt_regif_tb_top;

    localparam int          NUM_CH    = 3;
    localparam logic [31:0] TICK_FS   = 32'd10_000_000;
    localparam logic [31:0] ROUTE_CAP = 32'h00F0_0000;
    localparam int          NV        = 39;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [9:0]           bus_addr;
    logic                 bus_wr, bus_rd;
    logic [31:0]          bus_wdata;
    logic [31:0]          bus_rdata;
    logic                 bus_rvalid;
    logic [NUM_CH-1:0]    sts_set, sts_clr;
    logic [63:0]          cnt_value;
    logic                 glb_enable, glb_legacy;
    logic [NUM_CH*32-1:0] ch_cfg;
    logic [NUM_CH*64-1:0] ch_cmp, ch_route;
    logic [NUM_CH-1:0]    ch_cfg_wr, ch_cmp_wr;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    evt_regif #(.NUM_CH(NUM_CH), .TICK_FS(TICK_FS), .ROUTE_CAP(ROUTE_CAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .sts_set(sts_set), .sts_clr(sts_clr), .cnt_value(cnt_value),
        .glb_enable(glb_enable), .glb_legacy(glb_legacy), .ch_cfg(ch_cfg),
        .ch_cmp(ch_cmp), .ch_route(ch_route), .ch_cfg_wr(ch_cfg_wr), .ch_cmp_wr(ch_cmp_wr)
    );

    // {write, addr, data-or-expected, requirement number}
    localparam logic [50:0] VEC [NV] = '{
        {1'b0, 10'h000, 32'h8086A201, 8'd2},  // R2 capability low
        {1'b0, 10'h004, 32'h00989680, 8'd2},
        {1'b1, 10'h000, 32'hFFFFFFFF, 8'd2},
        {1'b1, 10'h004, 32'h00000000, 8'd2},
        {1'b0, 10'h000, 32'h8086A201, 8'd2},
        {1'b0, 10'h004, 32'h00989680, 8'd2},
        {1'b1, 10'h014, 32'hFFFFFFFF, 8'd3},  // R3 upper config word
        {1'b0, 10'h014, 32'h00000000, 8'd3},
        {1'b1, 10'h010, 32'hFFFFFFFE, 8'd3},
        {1'b0, 10'h010, 32'h00000002, 8'd3},
        {1'b1, 10'h010, 32'h00000000, 8'd3},
        {1'b0, 10'h010, 32'h00000000, 8'd3},
        {1'b0, 10'h100, 32'h00000030, 8'd1},  // R1 channel cfg reset
        {1'b1, 10'h100, 32'hFFFFFFFF, 8'd8},  // R8 write mask
        {1'b0, 10'h100, 32'h00007FFE, 8'd8},
        {1'b1, 10'h100, 32'h00000000, 8'd8},
        {1'b0, 10'h100, 32'h00000030, 8'd8},
        {1'b0, 10'h104, 32'h00F00000, 8'd7},  // R7 read-only upper cfg
        {1'b1, 10'h104, 32'h00000000, 8'd7},
        {1'b0, 10'h104, 32'h00F00000, 8'd7},
        {1'b0, 10'h108, 32'hFFFFFFFF, 8'd1},
        {1'b1, 10'h148, 32'h12345678, 8'd7},
        {1'b0, 10'h148, 32'h12345678, 8'd7},
        {1'b0, 10'h14C, 32'hFFFFFFFF, 8'd7},
        {1'b0, 10'h128, 32'hFFFFFFFF, 8'd7},
        {1'b1, 10'h130, 32'hCAFEF00D, 8'd7},
        {1'b0, 10'h130, 32'hCAFEF00D, 8'd7},
        {1'b0, 10'h134, 32'h00000000, 8'd7},
        {1'b1, 10'h168, 32'hAAAA5555, 8'd9},  // R9 channel 3 not built
        {1'b0, 10'h168, 32'h00000000, 8'd9},
        {1'b0, 10'h3E8, 32'h00000000, 8'd9},
        {1'b0, 10'h030, 32'h00000000, 8'd11}, // R11 unmapped
        {1'b1, 10'h10A, 32'h00000000, 8'd11},
        {1'b0, 10'h108, 32'hFFFFFFFF, 8'd11},
        {1'b0, 10'h101, 32'h00000000, 8'd11},
        {1'b1, 10'h0F0, 32'h89ABCDEF, 8'd5},  // R5 counter halves
        {1'b1, 10'h0F4, 32'h01234567, 8'd5},
        {1'b0, 10'h0F0, 32'h89ABCDEF, 8'd5},
        {1'b0, 10'h0F4, 32'h01234567, 8'd5}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a negedge, returns at the next negedge
    task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        logic [31:0] rd;
        rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_wdata = '0; sts_set = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 counter", cnt_value, 64'd0);
        chk("R1 enable/legacy", {62'd0, glb_enable, glb_legacy}, 64'd0);
        chk("R1 strobes", {58'd0, ch_cfg_wr, ch_cmp_wr}, 64'd0);
        chk("R1 rvalid", {63'd0, bus_rvalid}, 64'd0);
        bus_read(10'h020, rd);
        chk("R1 status", {32'd0, rd}, 64'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][50]) begin
                bus_write(VEC[i][49:40], VEC[i][39:8]);
            end else begin
                bus_read(VEC[i][49:40], rd);
                chk($sformatf("R%0d table entry %0d", VEC[i][7:0], i), {32'd0, rd}, {32'd0, VEC[i][39:8]});
            end
        end

        // R11 rvalid timing
        bus_addr = 10'h000; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R11 rvalid high", {63'd0, bus_rvalid}, 64'd1);
        @(negedge clk);
        chk("R11 rvalid low", {63'd0, bus_rvalid}, 64'd0);

        // R3 legacy bit at port
        bus_write(10'h010, 32'h2);
        chk("R3 legacy port", {62'd0, glb_enable, glb_legacy}, 64'd1);
        bus_write(10'h010, 32'h0);

        // R10 strobes
        bus_write(10'h120, 32'h40);
        chk("R10 cfg strobe", {61'd0, ch_cfg_wr}, 64'b010);
        chk("R10 cfg value", {32'd0, ch_cfg[63:32]}, 64'h70);
        @(negedge clk);
        chk("R10 strobe drops", {61'd0, ch_cfg_wr}, 64'd0);
        bus_write(10'h10C, 32'h5);
        chk("R10 cmp strobe", {61'd0, ch_cmp_wr}, 64'b001);
        chk("R10 cmp value", ch_cmp[63:0], 64'h00000005_FFFFFFFF);
        bus_write(10'h160, 32'hFFFF);
        chk("R9 no strobe", {58'd0, ch_cfg_wr, ch_cmp_wr}, 64'd0);

        // R4 run/halt
        bus_write(10'h0F0, 32'h0);
        bus_write(10'h0F4, 32'h0);
        bus_write(10'h010, 32'h1);
        chk("R4 enable set", {63'd0, glb_enable}, 64'd1);
        repeat (9) @(negedge clk);
        bus_write(10'h010, 32'h0);
        chk("R4 count after run", cnt_value, 64'd10);
        chk("R4 enable clear", {63'd0, glb_enable}, 64'd0);
        repeat (5) @(negedge clk);
        chk("R4 frozen", cnt_value, 64'd10);
        bus_read(10'h0F0, rd);
        chk("R4 frozen readback", {32'd0, rd}, 64'd10);
        bus_write(10'h010, 32'h1);
        bus_write(10'h010, 32'h0);
        chk("R4 resume", cnt_value, 64'd11);

        // R5 write while running
        bus_write(10'h010, 32'h1);
        bus_write(10'h0F0, 32'h100);
        bus_write(10'h010, 32'h0);
        chk("R5 write while running", cnt_value, 64'h101);

        // R6 status
        sts_set = 3'b101;
        @(negedge clk);
        sts_set = '0;
        bus_read(10'h020, rd);
        chk("R6 status set", {32'd0, rd}, 64'h5);
        bus_write(10'h020, 32'h0);
        chk("R6 zero write no clr", {61'd0, sts_clr}, 64'd0);
        bus_read(10'h020, rd);
        chk("R6 zero write keeps", {32'd0, rd}, 64'h5);
        bus_write(10'h020, 32'h6);
        chk("R6 clr pulse", {61'd0, sts_clr}, 64'b100);
        bus_read(10'h020, rd);
        chk("R6 cleared", {32'd0, rd}, 64'h1);
        sts_set = 3'b001;
        bus_write(10'h020, 32'h1);
        sts_set = '0;
        chk("R6 set wins no clr", {61'd0, sts_clr}, 64'd0);
        bus_read(10'h020, rd);
        chk("R6 set wins", {32'd0, rd}, 64'h1);
        bus_write(10'h020, 32'h1);
        chk("R6 clr bit0", {61'd0, sts_clr}, 64'b001);
        bus_read(10'h020, rd);
        chk("R6 all clear", {32'd0, rd}, 64'h0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule